// File: doc/BRIEF.md
# Static Memory Read Strobe Sequencer

This block runs read accesses on an external asynchronous static memory bus for an internal host. The host presents a byte address, a chip-select index and a device data-bus width with a valid strobe. While idle, the sequencer accepts the request. It places the address and byte selects on the pins and then generates an active-low read strobe and an active-low chip-select line, each with its own setup and pulse window. The windows are counted in clock cycles inside one shared access length.

The timing counts come in on static input ports and are captured at acceptance. The read data bus is sampled on the clock edge at which the read strobe returns high. The captured word goes back to the host with a one-cycle completion pulse once the whole access length has elapsed. Between accesses every strobe rests high and the address and byte selects keep their last values.

Top module: `sram_rd_sequencer`

## Requirements
- R1: After reset, and whenever no access is in progress, `mem_rd_n` and every `mem_cs_n` line are high and `req_ready` is high. `rsp_done` is low after reset.
- R2: Cycle t = 0 is the first clock cycle after the acceptance edge. Within an access, `mem_rd_n` is low exactly in cycles t with RS <= t < RS + RP', where RS = `cfg_rd_setup` and RP' = max(`cfg_rd_pulse`, 1).
- R3: Within an access, the line `mem_cs_n[req_cs]` is low exactly in cycles t with CS <= t < CS + CP', where CS = `cfg_cs_setup` and CP' = max(`cfg_cs_pulse`, 1). This window is independent of the read strobe. All other chip-select lines stay high.
- R4: An access lasts L = max(`cfg_cycle`, RS + RP', CS + CP') cycles, and `req_ready` is low throughout it. `rsp_done` is high for exactly one cycle, cycle t = L, and `req_ready` is high in that cycle.
- R5: From cycle 0, `mem_addr` shows the request address with its low bits forced according to `req_width`. Code 0 (8-bit device) keeps all bits. Code 1 (16-bit) forces bit 0 to 0. Codes 2 and 3 (32-bit) force bits 1 and 0 to 0.
- R6: `mem_bs_n` changes at the same edge as `mem_addr`. Its value is 4'b1110 for width code 0, 4'b1100 for code 1, and 4'b0000 for codes 2 and 3.
- R7: `rsp_data` takes the value of `mem_data_in` at the clock edge that ends cycle RS + RP' - 1, which is the edge where `mem_rd_n` is driven high again. It holds that value until the next capture.
- R8: A request presented while an access is in progress has no effect. Address, byte selects, chip-select line and access length all remain those of the running access.
- R9: A read setup count of zero drives `mem_rd_n` low in cycle 0. A read pulse count of zero gives a one-cycle low pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | ADDR_W | Byte address of the read |
| req_cs | input | CS_IDX_W | Index of the chip-select line to assert |
| req_width | input | 2 | Device width code: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| req_ready | output | 1 | High while idle; a request is taken when this and req_valid are high |
| cfg_rd_setup | input | CNT_W | Read strobe setup cycles |
| cfg_rd_pulse | input | CNT_W | Read strobe low cycles (0 acts as 1) |
| cfg_cs_setup | input | CNT_W | Chip-select setup cycles |
| cfg_cs_pulse | input | CNT_W | Chip-select low cycles (0 acts as 1) |
| cfg_cycle | input | CNT_W | Nominal total access length in cycles |
| mem_addr | output | ADDR_W | External address bus |
| mem_bs_n | output | DATA_W/8 | Active-low byte selects |
| mem_cs_n | output | NCS | Active-low chip-select lines |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_data_in | input | DATA_W | External read data bus |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Captured read data |

## Verification
The assertions assume that reset is asserted before the first request. They place no condition on the timing counts, request fields or data bus. The one on the capture edge relies on `mem_data_in` being an ordinary synchronous input that is sampled at the same edge as the strobe. The stimulus respects this by changing the data bus, requests and configuration only at falling clock edges. It also tags each data word with its access number and cycle index, so a capture one cycle early or late shows up. The request is left asserted with altered fields during an access and is dropped before the completion cycle, so the only acceptances are the intended ones.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

  // Device data-bus width code carried with each request.
  typedef enum logic [1:0] {
    DEV_W8      = 2'd0,
    DEV_W16     = 2'd1,
    DEV_W32     = 2'd2,
    DEV_W32_ALT = 2'd3
  } dev_width_e;

  // Address bits below the device word that are not driven as address.
  function automatic logic [1:0] low_addr_mask(dev_width_e w);
    case (w)
      DEV_W8:  return 2'b00;
      DEV_W16: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  // Number of byte lanes a device of this width occupies.
  function automatic logic [7:0] lanes_for_width(dev_width_e w);
    case (w)
      DEV_W8:  return 8'd1;
      DEV_W16: return 8'd2;
      default: return 8'd4;
    endcase
  endfunction

endpackage

// File: rtl/sram_rd_timing.sv
// Turns the raw setup/pulse/cycle counts into window bounds and the
// effective access length (stretched to cover both pulses).
module sram_rd_timing #(
  parameter int CNT_W = 4,
  parameter int LEN_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0] rd_setup,
  input  logic [CNT_W-1:0] rd_pulse,
  input  logic [CNT_W-1:0] cs_setup,
  input  logic [CNT_W-1:0] cs_pulse,
  input  logic [CNT_W-1:0] cycle_len,
  output logic [LEN_W-1:0] rd_start,
  output logic [LEN_W-1:0] rd_stop,
  output logic [LEN_W-1:0] cs_start,
  output logic [LEN_W-1:0] cs_stop,
  output logic [LEN_W-1:0] total_len
);

  logic [LEN_W-1:0] rd_width;
  logic [LEN_W-1:0] cs_width;
  logic [LEN_W-1:0] len_a;

  always_comb begin
    rd_width = (rd_pulse == '0) ? LEN_W'(1) : LEN_W'(rd_pulse);
    cs_width = (cs_pulse == '0) ? LEN_W'(1) : LEN_W'(cs_pulse);
    rd_start = LEN_W'(rd_setup);
    cs_start = LEN_W'(cs_setup);
    rd_stop  = rd_start + rd_width;
    cs_stop  = cs_start + cs_width;
    len_a    = (rd_stop > LEN_W'(cycle_len)) ? rd_stop : LEN_W'(cycle_len);
    total_len = (cs_stop > len_a) ? cs_stop : len_a;
  end

endmodule

// File: rtl/sram_rd_window.sv
// Registered active-low strobe for one or more lanes. The register is
// loaded with the value for the coming cycle (t_next), so the pin changes
// exactly at the cycle boundary.
module sram_rd_window #(
  parameter int LANES = 1,
  parameter int T_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_next,
  input  logic [T_W-1:0]   t_next,
  input  logic [T_W-1:0]   win_start,
  input  logic [T_W-1:0]   win_stop,
  input  logic [LANES-1:0] lane_sel,
  output logic [LANES-1:0] strb_n
);

  logic             in_win;
  logic [LANES-1:0] nxt_n;

  assign in_win = active_next && (t_next >= win_start) && (t_next < win_stop);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign nxt_n[g] = !(in_win && lane_sel[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) strb_n <= '1;
    else     strb_n <= nxt_n;
  end

endmodule

// File: rtl/sram_rd_cs_decode.sv
// Binary chip-select index to one-hot lane select.
module sram_rd_cs_decode #(
  parameter int LANES = 8,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic [LANES-1:0] onehot
);

  for (genvar g = 0; g < LANES; g++) begin : g_dec
    assign onehot[g] = (idx == IDX_W'(g));
  end

endmodule

// File: rtl/sram_rd_addr_map.sv
// Address low-bit forcing and byte-select pattern from the device width.
module sram_rd_addr_map
  import sram_rd_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int BS_W   = 4
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  dev_width_e        width,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BS_W-1:0]   bs_n
);

  logic [1:0] mask;
  logic [7:0] lanes_used;

  assign mask       = low_addr_mask(width);
  assign lanes_used = lanes_for_width(width);
  assign addr_out   = {addr_in[ADDR_W-1:2], addr_in[1:0] & ~mask};

  for (genvar g = 0; g < BS_W; g++) begin : g_bs
    assign bs_n[g] = !(8'(g) < lanes_used);
  end

endmodule

// File: rtl/sram_rd_sequencer.sv
module sram_rd_sequencer
  import sram_rd_pkg::*;
#(
  parameter  int ADDR_W   = 26,
  parameter  int DATA_W   = 32,
  parameter  int CNT_W    = 4,
  parameter  int NCS      = 8,
  localparam int CS_IDX_W = $clog2(NCS),
  localparam int BS_W     = DATA_W / 8,
  localparam int LEN_W    = CNT_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [CS_IDX_W-1:0] req_cs,
  input  logic [1:0]          req_width,
  output logic                req_ready,
  input  logic [CNT_W-1:0]    cfg_rd_setup,
  input  logic [CNT_W-1:0]    cfg_rd_pulse,
  input  logic [CNT_W-1:0]    cfg_cs_setup,
  input  logic [CNT_W-1:0]    cfg_cs_pulse,
  input  logic [CNT_W-1:0]    cfg_cycle,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BS_W-1:0]     mem_bs_n,
  output logic [NCS-1:0]      mem_cs_n,
  output logic                mem_rd_n,
  input  logic [DATA_W-1:0]   mem_data_in,
  output logic                rsp_done,
  output logic [DATA_W-1:0]   rsp_data
);

  // ---------------- access state ----------------
  logic                busy_q;
  logic [LEN_W-1:0]    cnt_q;
  logic [LEN_W-1:0]    rd_start_q, rd_stop_q, cs_start_q, cs_stop_q, len_q;
  logic [CS_IDX_W-1:0] cs_idx_q;

  // ---------------- timing from the raw counts ----------------
  logic [LEN_W-1:0] c_rd_start, c_rd_stop, c_cs_start, c_cs_stop, c_len;

  sram_rd_timing #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_timing (
    .rd_setup  (cfg_rd_setup),
    .rd_pulse  (cfg_rd_pulse),
    .cs_setup  (cfg_cs_setup),
    .cs_pulse  (cfg_cs_pulse),
    .cycle_len (cfg_cycle),
    .rd_start  (c_rd_start),
    .rd_stop   (c_rd_stop),
    .cs_start  (c_cs_start),
    .cs_stop   (c_cs_stop),
    .total_len (c_len)
  );

  // ---------------- sequencing ----------------
  logic             accept;
  logic [LEN_W-1:0] cnt_inc;
  logic             last_cycle;
  logic             active_next;
  logic [LEN_W-1:0] t_next;
  logic [LEN_W-1:0] u_rd_start, u_rd_stop, u_cs_start, u_cs_stop;

  assign accept      = req_valid && !busy_q;
  assign cnt_inc     = cnt_q + LEN_W'(1);
  assign last_cycle  = busy_q && (cnt_inc == len_q);
  assign active_next = accept || (busy_q && (cnt_inc < len_q));
  assign t_next      = accept ? '0 : cnt_inc;
  assign u_rd_start  = accept ? c_rd_start : rd_start_q;
  assign u_rd_stop   = accept ? c_rd_stop  : rd_stop_q;
  assign u_cs_start  = accept ? c_cs_start : cs_start_q;
  assign u_cs_stop   = accept ? c_cs_stop  : cs_stop_q;
  assign req_ready   = !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      rd_start_q <= '0;
      rd_stop_q  <= '0;
      cs_start_q <= '0;
      cs_stop_q  <= '0;
      len_q      <= '0;
      cs_idx_q   <= '0;
      rsp_done   <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      if (accept) begin
        busy_q     <= 1'b1;
        cnt_q      <= '0;
        rd_start_q <= c_rd_start;
        rd_stop_q  <= c_rd_stop;
        cs_start_q <= c_cs_start;
        cs_stop_q  <= c_cs_stop;
        len_q      <= c_len;
        cs_idx_q   <= req_cs;
      end else if (busy_q) begin
        if (last_cycle) begin
          busy_q   <= 1'b0;
          rsp_done <= 1'b1;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  // ---------------- read data capture (edge where the strobe rises) ----------------
  always_ff @(posedge clk) begin
    if (rst)                                   rsp_data <= '0;
    else if (busy_q && (cnt_inc == rd_stop_q)) rsp_data <= mem_data_in;
  end

  // ---------------- address and byte selects ----------------
  logic [ADDR_W-1:0] map_addr;
  logic [BS_W-1:0]   map_bs_n;

  sram_rd_addr_map #(.ADDR_W(ADDR_W), .BS_W(BS_W)) u_addr_map (
    .addr_in  (req_addr),
    .width    (dev_width_e'(req_width)),
    .addr_out (map_addr),
    .bs_n     (map_bs_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_bs_n <= '1;
    end else if (accept) begin
      mem_addr <= map_addr;
      mem_bs_n <= map_bs_n;
    end
  end

  // ---------------- strobes ----------------
  logic [CS_IDX_W-1:0] cs_idx_use;
  logic [NCS-1:0]      cs_sel;

  assign cs_idx_use = accept ? req_cs : cs_idx_q;

  sram_rd_cs_decode #(.LANES(NCS), .IDX_W(CS_IDX_W)) u_cs_decode (
    .idx    (cs_idx_use),
    .onehot (cs_sel)
  );

  sram_rd_window #(.LANES(1), .T_W(LEN_W)) u_rd_window (
    .clk         (clk),
    .rst         (rst),
    .active_next (active_next),
    .t_next      (t_next),
    .win_start   (u_rd_start),
    .win_stop    (u_rd_stop),
    .lane_sel    (1'b1),
    .strb_n      (mem_rd_n)
  );

  sram_rd_window #(.LANES(NCS), .T_W(LEN_W)) u_cs_window (
    .clk         (clk),
    .rst         (rst),
    .active_next (active_next),
    .t_next      (t_next),
    .win_start   (u_cs_start),
    .win_stop    (u_cs_stop),
    .lane_sel    (cs_sel),
    .strb_n      (mem_cs_n)
  );

  // ---------------- assertions ----------------
  assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_rd_n && (&mem_cs_n)));

  assert_cs_single_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  assert_done_ready_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> ($stable(mem_addr) && $stable(mem_bs_n)));

  assert_capture_edge_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_n) |-> (rsp_data == $past(mem_data_in)));

endmodule

// File: tb/sram_rd_sequencer_bench.sv
module sram_rd_sequencer_bench;

  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int NCS    = 8;
  localparam int LIMIT  = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [2:0]        req_cs;
  logic [1:0]        req_width;
  logic              req_ready;
  logic [CNT_W-1:0]  cfg_rd_setup, cfg_rd_pulse, cfg_cs_setup, cfg_cs_pulse, cfg_cycle;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0]        mem_bs_n;
  logic [NCS-1:0]    mem_cs_n;
  logic              mem_rd_n;
  logic [DATA_W-1:0] mem_data_in;
  logic              rsp_done;
  logic [DATA_W-1:0] rsp_data;

  int checks   = 0;
  int failures = 0;
  int cyc_cnt  = 0;

  always #4 clk = ~clk;

  sram_rd_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NCS(NCS))
  u_sram_rd_sequencer (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_addr (req_addr), .req_cs (req_cs),
    .req_width (req_width), .req_ready (req_ready),
    .cfg_rd_setup (cfg_rd_setup), .cfg_rd_pulse (cfg_rd_pulse),
    .cfg_cs_setup (cfg_cs_setup), .cfg_cs_pulse (cfg_cs_pulse), .cfg_cycle (cfg_cycle),
    .mem_addr (mem_addr), .mem_bs_n (mem_bs_n), .mem_cs_n (mem_cs_n),
    .mem_rd_n (mem_rd_n), .mem_data_in (mem_data_in),
    .rsp_done (rsp_done), .rsp_data (rsp_data)
  );

  task automatic check(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt >= LIMIT) begin
      failures++;
      $display("FAIL watchdog R4 actual=%0d expected=<%0d", cyc_cnt, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_access(input int k, input int rs, input int rp, input int css,
                            input int csp, input int cyc);
    int rpe, cpe, len, cap_t, w;
    logic [ADDR_W-1:0] a, ea;
    logic [3:0]        ebs;
    logic [2:0]        ci;
    logic [NCS-1:0]    ecs;
    logic              erd;
    logic [DATA_W-1:0] edata;

    rpe = (rp == 0) ? 1 : rp;
    cpe = (csp == 0) ? 1 : csp;
    len = cyc;
    if (rs + rpe > len)  len = rs + rpe;
    if (css + cpe > len) len = css + cpe;
    w  = k % 4;
    ci = 3'((k * 3) % 8);
    a  = ADDR_W'(32'(k) * 32'h9E3779B1 + 32'h0123457);
    case (w)
      0:       begin ea = a;                          ebs = 4'b1110; end
      1:       begin ea = {a[ADDR_W-1:1], 1'b0};      ebs = 4'b1100; end
      default: begin ea = {a[ADDR_W-1:2], 2'b00};     ebs = 4'b0000; end
    endcase
    cap_t = rs + rpe - 1;
    edata = {16'(k), 16'(cap_t)};

    cfg_rd_setup = CNT_W'(rs);
    cfg_rd_pulse = CNT_W'(rp);
    cfg_cs_setup = CNT_W'(css);
    cfg_cs_pulse = CNT_W'(csp);
    cfg_cycle    = CNT_W'(cyc);
    req_valid    = 1'b1;
    req_addr     = a;
    req_cs       = ci;
    req_width    = 2'(w);
    @(posedge clk);
    @(negedge clk);

    for (int t = 0; t < len; t++) begin
      mem_data_in = {16'(k), 16'(t)};
      erd = !(t >= rs && t < rs + rpe);
      ecs = '1;
      if (t >= css && t < css + cpe) ecs[ci] = 1'b0;
      check(mem_rd_n == erd, (rs == 0 || rp == 0) ? "R9" : "R2", 64'(mem_rd_n), 64'(erd));
      check(mem_cs_n == ecs, "R3", 64'(mem_cs_n), 64'(ecs));
      check(mem_addr == ea, (t == 0) ? "R5" : "R8", 64'(mem_addr), 64'(ea));
      check(mem_bs_n == ebs, "R6", 64'(mem_bs_n), 64'(ebs));
      check(!req_ready && !rsp_done, "R4", 64'({req_ready, rsp_done}), 64'(0));
      if (t == 0) begin
        // R8: a different request held during the access must be ignored
        req_addr  = ~a;
        req_cs    = ci + 3'd1;
        req_width = 2'(w + 1);
      end
      if (t == len - 1) req_valid = 1'b0;
      @(negedge clk);
    end

    check(rsp_done && req_ready, "R4", 64'({rsp_done, req_ready}), 64'(3));
    check(rsp_data == edata, "R7", 64'(rsp_data), 64'(edata));
    check(mem_rd_n && (&mem_cs_n), "R1", 64'({mem_rd_n, mem_cs_n}), 64'(9'h1FF));
    check(mem_addr == ea && mem_bs_n == ebs, "R8", 64'(mem_addr), 64'(ea));
    @(negedge clk);
    check(!rsp_done, "R4", 64'(rsp_done), 64'(0));
    check(rsp_data == edata, "R7", 64'(rsp_data), 64'(edata));
  endtask

  initial begin
    int k;
    int cyc_set [4];
    cyc_set = '{0, 5, 9, 15};
    req_valid    = 1'b0;
    req_addr     = '0;
    req_cs       = '0;
    req_width    = '0;
    cfg_rd_setup = '0;
    cfg_rd_pulse = '0;
    cfg_cs_setup = '0;
    cfg_cs_pulse = '0;
    cfg_cycle    = '0;
    mem_data_in  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(mem_rd_n == 1'b1, "R1", 64'(mem_rd_n), 64'(1));
    check(mem_cs_n == '1, "R1", 64'(mem_cs_n), 64'(8'hFF));
    check(req_ready == 1'b1, "R1", 64'(req_ready), 64'(1));
    check(rsp_done == 1'b0, "R1", 64'(rsp_done), 64'(0));
    check(mem_bs_n == 4'hF, "R1", 64'(mem_bs_n), 64'(4'hF));

    k = 0;
    for (int rs = 0; rs < 4; rs++)
      for (int rp = 0; rp < 4; rp++)
        for (int cs = 0; cs < 4; cs++)
          for (int cp = 0; cp < 4; cp++)
            for (int ci = 0; ci < 4; ci++) begin
              run_access(k, rs, rp, cs, cp, cyc_set[ci]);
              k++;
            end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule